// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block lets a single-clock host use an external asynchronous static RAM of 32K bytes. The host presents one request at a time on a valid/ready handshake: a read or a write, a 15-bit word address and, for writes, a data byte. The controller then runs the memory's active-low chip-select, write strobe and output-enable lines and its address pins. It also controls the data bus through three separate signals: a drive value, a drive enable and a sampled input. Every phase of a memory cycle lasts a whole number of clock periods. The controller derives that number at elaboration from the memory's nanosecond limits and the `CLK_PERIOD_NS` parameter. Each phase count is the required time divided by the period, rounded up, and is never less than one cycle.

Writes use the write strobe as the controlling edge. Chip-select falls first, the strobe pulses low while the data driver is on, and then one recovery cycle keeps the address and data steady after the strobe rises. Reads hold chip-select and output-enable low for the access window and capture the bus on the edge that closes that window. After every read, turnaround cycles with both chip-select and output-enable high follow, so the memory releases the bus before the controller can drive it again. The host sees read data with a one-cycle valid pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` and `rdata_valid` are 0, and `req_ready` is 1.
- R2: An accepted write keeps `sram_ce_n` low for the whole cycle. The cycle starts with a setup phase of max(1, ceil(0/T)) cycles with `sram_we_n` high. Then `sram_we_n` is low for max(ceil(6/T), ceil(3.5/T)) cycles. Last comes one recovery cycle with `sram_we_n` high. Here T = `CLK_PERIOD_NS`, so the phases last 1, 2 and 1 cycles at T = 4.
- R3: During a write `sram_oe_n` stays high. `sram_dq_oe` is 1 exactly during the strobe-low and recovery phases, and `sram_dq_out` then carries the accepted byte.
- R4: An accepted read holds `sram_ce_n` and `sram_oe_n` low and `sram_we_n` high for max(ceil(5/T), ceil(4/T)) cycles (2 at T = 4), with `sram_dq_oe` 0.
- R5: The controller samples `sram_dq_in` on the clock edge that ends the read access window. `rdata` shows that byte, and `rdata_valid` is 1 for exactly the one cycle that follows.
- R6: After the read access window come max(1, ceil(3/T)) cycles with `sram_ce_n` and `sram_oe_n` high before the controller is idle again. `sram_dq_oe` is never 1 in a cycle where `sram_oe_n` is low, nor in the cycle right after one.
- R7: `req_ready` is 1 only while the controller is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle, including its turnaround, has finished.
- R8: `sram_addr` carries the address of the accepted request and does not change while `sram_ce_n` stays low.
- R9: A read returns the byte most recently written to that address, including at the lowest address 0 and the highest address 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rdata | output | 8 | Captured read byte |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` |
| sram_addr | output | 15 | Memory address pins |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | 8 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The delicate coincidence is a write request that waits on the handshake while a read is still finishing. The write's data driver could then turn on in the same cycle that the memory still drives the bus, or in the cycle right after output-enable rises. The bench provokes this by issuing a write immediately after each read with `req_valid` held high, so the write is taken in the first idle cycle after the turnaround. In every cycle the bench's bus model judges the result: it flags any cycle where the driver is on while the memory is selected for output, or one cycle after that. The per-cycle strobe queue also checks that the write's setup phase starts only after the turnaround cycles have run.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_W_SETUP,
        PH_W_STROBE,
        PH_W_RECOVER,
        PH_R_ACCESS,
        PH_R_TURN
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBES_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    // Cycles needed for a limit given in tenths of a nanosecond, rounded up, at least one.
    function automatic int tenths_to_cycles(input int need_ns10, input int period_ns);
        int c;
        c = (need_ns10 + period_ns * 10 - 1) / (period_ns * 10);
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t phase_strobes(input phase_e p);
        strobe_t s;
        s = STROBES_QUIET;
        case (p)
            PH_W_SETUP:   s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            PH_W_STROBE:  s = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            PH_W_RECOVER: s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
            PH_R_ACCESS:  s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
            default:      s = STROBES_QUIET;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int N_AS = 1,
    parameter int N_WP = 2,
    parameter int N_WH = 1,
    parameter int N_RA = 2,
    parameter int N_TA = 1,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_write,
    input  logic          timer_done,
    output phase_e        phase_q,
    output phase_e        phase_d,
    output logic          timer_load,
    output logic [CW-1:0] timer_val,
    output logic          capture
);
    function automatic logic [CW-1:0] span_m1(input phase_e p);
        case (p)
            PH_W_SETUP:   return CW'(N_AS - 1);
            PH_W_STROBE:  return CW'(N_WP - 1);
            PH_W_RECOVER: return CW'(N_WH - 1);
            PH_R_ACCESS:  return CW'(N_RA - 1);
            PH_R_TURN:    return CW'(N_TA - 1);
            default:      return '0;
        endcase
    endfunction

    function automatic phase_e follow(input phase_e p);
        case (p)
            PH_W_SETUP:   return PH_W_STROBE;
            PH_W_STROBE:  return PH_W_RECOVER;
            PH_R_ACCESS:  return PH_R_TURN;
            default:      return PH_IDLE;
        endcase
    endfunction

    always_comb begin
        phase_d    = phase_q;
        timer_load = 1'b0;
        if (phase_q == PH_IDLE) begin
            if (start) begin
                phase_d    = start_write ? PH_W_SETUP : PH_R_ACCESS;
                timer_load = 1'b1;
            end
        end else if (timer_done) begin
            phase_d    = follow(phase_q);
            timer_load = 1'b1;
        end
        timer_val = span_m1(phase_d);
    end

    assign capture = (phase_q == PH_R_ACCESS) && timer_done;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end
endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  phase_e            phase_d,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output strobe_t           strobes_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            strobes_q <= STROBES_QUIET;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            strobes_q <= phase_strobes(phase_d);
            rvalid_q  <= capture;
            if (capture) rdata_q <= dq_in;
        end
    end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_ADDR_SETUP_NS10 = 0,
    parameter int T_WE_PULSE_NS10   = 60,
    parameter int T_DATA_SETUP_NS10 = 35,
    parameter int T_RECOVER_NS10    = 0,
    parameter int T_ADDR_ACC_NS10   = 50,
    parameter int T_OE_ACC_NS10     = 40,
    parameter int T_RELEASE_NS10    = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int N_AS  = tenths_to_cycles(T_ADDR_SETUP_NS10, CLK_PERIOD_NS);
    localparam int N_WP  = max_int(tenths_to_cycles(T_WE_PULSE_NS10, CLK_PERIOD_NS),
                                   tenths_to_cycles(T_DATA_SETUP_NS10, CLK_PERIOD_NS));
    localparam int N_WH  = tenths_to_cycles(T_RECOVER_NS10, CLK_PERIOD_NS);
    localparam int N_RA  = max_int(tenths_to_cycles(T_ADDR_ACC_NS10, CLK_PERIOD_NS),
                                   tenths_to_cycles(T_OE_ACC_NS10, CLK_PERIOD_NS));
    localparam int N_TA  = tenths_to_cycles(T_RELEASE_NS10, CLK_PERIOD_NS);
    localparam int N_MAX = max_int(max_int(max_int(N_AS, N_WP), max_int(N_WH, N_RA)), N_TA);
    localparam int CW    = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    phase_e        phase_q;
    phase_e        phase_d;
    logic          timer_load;
    logic [CW-1:0] timer_val;
    logic          timer_done;
    logic          capture;
    logic          accept;
    strobe_t       strobes_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;

    sram_seq_fsm #(
        .N_AS(N_AS), .N_WP(N_WP), .N_WH(N_WH), .N_RA(N_RA), .N_TA(N_TA), .CW(CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_write(req_write),
        .timer_done (timer_done),
        .phase_q    (phase_q),
        .phase_d    (phase_d),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .capture    (capture)
    );

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .load_val(timer_val),
        .done    (timer_done)
    );

    sram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .phase_d  (phase_d),
        .capture  (capture),
        .dq_in    (sram_dq_in),
        .addr_q   (sram_addr),
        .wdata_q  (wdata_q),
        .strobes_q(strobes_q),
        .rdata_q  (rdata),
        .rvalid_q (rdata_valid)
    );

    assign sram_ce_n   = strobes_q.ce_n;
    assign sram_we_n   = strobes_q.we_n;
    assign sram_oe_n   = strobes_q.oe_n;
    assign sram_dq_oe  = strobes_q.drive;
    assign sram_dq_out = wdata_q;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int N_WP   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rdata_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)             low_run <= '0;
        else if (!sram_we_n) low_run <= low_run + 1'b1;
        else                 low_run <= '0;
    end

    // R2
    we_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n);

    // R2
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (low_run == 16'(N_WP)));

    // R3
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_oe_n);

    // R4
    read_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (sram_we_n && !sram_ce_n && !sram_dq_oe));

    // R5
    rv_single_chk: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);

    // R6
    drive_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |=> !sram_dq_oe);

    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W), .N_WP(N_WP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rdata_valid(rdata_valid),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;
    localparam int PERIOD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_valid;
    logic [14:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    always #2 clk = ~clk;

    sram_strobe_ctrl #(.CLK_PERIOD_NS(PERIOD)) u_sram_strobe_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata(rdata), .rdata_valid(rdata_valid), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int n_chk = 0;
    int n_err = 0;

    function automatic int cyc(input int ns10);
        int c;
        c = (ns10 + PERIOD * 10 - 1) / (PERIOD * 10);
        return (c < 1) ? 1 : c;
    endfunction

    int e_as, e_wp, e_wh, e_ra, e_ta;
    initial begin
        e_as = cyc(0);
        e_wp = (cyc(60) > cyc(35)) ? cyc(60) : cyc(35);
        e_wh = cyc(0);
        e_ra = (cyc(50) > cyc(40)) ? cyc(50) : cyc(40);
        e_ta = cyc(30);
    end

    function automatic logic [7:0] fill(input logic [14:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // memory model (what the controller really wrote) and the bench's own expectation
    logic [7:0] mem    [int];
    logic [7:0] shadow [int];

    always_comb begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n)
            sram_dq_in = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : fill(sram_addr);
        else
            sram_dq_in = 8'h00;
    end

    typedef struct {
        bit         ce_n, we_n, oe_n, drv, rv;
        logic [14:0] addr;
        logic [7:0]  data;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic exp_t mk(input bit c, input bit w, input bit o, input bit d, input bit r,
                                input logic [14:0] a, input logic [7:0] v);
        exp_t e;
        e.ce_n = c; e.we_n = w; e.oe_n = o; e.drv = d; e.rv = r; e.addr = a; e.data = v;
        return e;
    endfunction

    bit prev_oe_low = 0;

    always @(negedge clk) begin : monitor
        exp_t e;
        bit busy;
        if (!rst) begin
            busy = (exp_q.size() > 0);
            if (busy) e = exp_q.pop_front();
            else      e = mk(1, 1, 1, 0, 0, '0, '0);
            chk(sram_ce_n == e.ce_n, "R2/R4 ce_n", sram_ce_n, e.ce_n);
            chk(sram_we_n == e.we_n, "R2 we_n", sram_we_n, e.we_n);
            chk(sram_oe_n == e.oe_n, "R3/R4/R6 oe_n", sram_oe_n, e.oe_n);
            chk(sram_dq_oe == e.drv, "R3 dq_oe", sram_dq_oe, e.drv);
            chk(req_ready == !busy, "R7 req_ready", req_ready, !busy);
            chk(rdata_valid == e.rv, "R5 rdata_valid", rdata_valid, e.rv);
            if (busy && !e.ce_n) chk(sram_addr == e.addr, "R8 sram_addr", sram_addr, e.addr);
            if (e.drv) chk(sram_dq_out == e.data, "R3 dq_out", sram_dq_out, e.data);
            if (e.rv)  chk(rdata == e.data, "R5/R9 rdata", rdata, e.data);
            // R6 bus model: controller drive must not overlap or immediately follow memory output
            chk(!(sram_dq_oe && ((!sram_ce_n && !sram_oe_n) || prev_oe_low)),
                "R6 bus contention", sram_dq_oe, 0);
            if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[int'(sram_addr)] = sram_dq_out;
            prev_oe_low = !sram_ce_n && !sram_oe_n;

            if (req_valid && req_ready) begin
                if (req_write) begin
                    shadow[int'(req_addr)] = req_wdata;
                    for (int i = 0; i < e_as; i++) exp_q.push_back(mk(0, 1, 1, 0, 0, req_addr, req_wdata));
                    for (int i = 0; i < e_wp; i++) exp_q.push_back(mk(0, 0, 1, 1, 0, req_addr, req_wdata));
                    for (int i = 0; i < e_wh; i++) exp_q.push_back(mk(0, 1, 1, 1, 0, req_addr, req_wdata));
                end else begin
                    logic [7:0] v;
                    v = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : fill(req_addr);
                    for (int i = 0; i < e_ra; i++) exp_q.push_back(mk(0, 1, 0, 0, 0, req_addr, v));
                    for (int i = 0; i < e_ta; i++) exp_q.push_back(mk(1, 1, 1, 0, (i == 0), req_addr, v));
                end
            end
        end
    end

    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes in reset", {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
        chk(!sram_dq_oe && !rdata_valid, "R1 driver/valid in reset", {sram_dq_oe, rdata_valid}, 0);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #1;

        issue(1, 15'h000A, 8'hA5);            // R2 R3
        issue(0, 15'h000A, 8'h00);            // R4 R5 R9
        issue(1, 15'h7FFF, 8'h3C);            // R9 high address, write right after read (R6)
        issue(0, 15'h7FFF, 8'h00);
        issue(1, 15'h0000, 8'hC3);            // R9 low address
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h1234, 8'h00);            // unwritten address
        repeat (3) @(posedge clk);
        #1;
        issue(1, 15'h000A, 8'h11);            // overwrite then read back (R9)
        issue(0, 15'h000A, 8'h00);
        for (int i = 0; i < 24; i++) begin
            logic [14:0] a;
            a = 15'((i * 1237 + 5) % 32768);
            if (i % 3 == 2) issue(0, 15'((((i - 1) * 1237) + 5) % 32768), 8'h00);
            else            issue(1, a, 8'(i * 29 + 7));
            if (i % 5 == 0) begin
                repeat (2) @(posedge clk);
                #1;
            end
        end
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R7 all cycles finished", exp_q.size(), 0);
        finish_run();
    end
endmodule